// File: doc/BRIEF.md
# Page-Table Word Cache

This block sits between a page-table walker and the memory read port and keeps recently fetched page-directory and page-table words close to the walker. It is direct-mapped: each line holds four 32-bit words, a lookup address selects one line through address bits [9:4], and the bits above those form the tag. A lookup that hits returns its word on the next cycle. A lookup that misses issues one line fetch and returns the word once the line arrives. At that point the line is also installed.

Software keeps the cache coherent with the page tables in memory by writing flush commands. A flush either invalidates every line or invalidates the single line that holds a given physical address. A configuration register turns caching on and off. While caching is off, every lookup reads memory and nothing is installed. Two statistics counters record hits and misses. They are enabled and cleared through the same configuration word.

Top module: `pte_word_cache`

## Requirements
- R1: After reset the configuration register reads 0x2000003F, both statistics counters read zero, and every line is invalid, so the first lookup of any address fetches from memory.
- R2: A lookup that hits raises `rd_valid` on the cycle after it is accepted. It returns the addressed word of the stored line and issues no memory fetch.
- R3: A lookup that misses raises `fetch_valid` for exactly one cycle, on the cycle after acceptance, with the line-aligned address (low four bits zero). `rd_valid` follows on the cycle after `fill_valid`.
- R4: Line index is address bits [9:4], word select is bits [3:2] (word k sits at `fill_line` bits [32k+31:32k]), and the tag is bits [31:10]. A miss to a different tag at the same index replaces the line.
- R5: With configuration bit 29 clear, every lookup fetches from memory and returns the fetched word. No line is installed and no statistic is counted.
- R6: A write to the flush register (`reg_sel`=1) with bit 0 clear invalidates every line.
- R7: A write to the flush register with bit 0 set takes bits [31:4] as a physical line address. It invalidates that index only when the stored tag matches, and leaves all other lines unchanged.
- R8: A flush that covers the line of a fill in progress (flush-all, or flush-by-address of that line) leaves that line invalid after the fill completes. The walker still receives the fetched word.
- R9: With configuration bit 31 set, each hit adds one to the hit counter (`reg_sel`=2) and each cached miss adds one to the miss counter (`reg_sel`=3). With bit 31 clear, neither counter changes.
- R10: Writing the configuration register with bit 30 set zeroes both counters. The clear takes precedence over an increment in the same cycle, and bit 30 always reads back as 0.
- R11: `lk_ready` is low from the cycle a miss is accepted until its fill has been taken. Lookups are accepted only while it is high.
- R12: Configuration bits 31, 29 and [5:0] are stored and read back as written. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Walker lookup request |
| lk_addr | input | 32 | Physical byte address of the requested word |
| lk_ready | output | 1 | Cache idle, lookup can be accepted |
| rd_valid | output | 1 | One-cycle pulse with the returned word |
| rd_data | output | 32 | Returned page-table word |
| fetch_valid | output | 1 | One-cycle line fetch request to memory |
| fetch_addr | output | 32 | Line-aligned fetch address |
| fill_valid | input | 1 | Memory returns the requested line |
| fill_line | input | 128 | Line data, word k at bits [32k+31:32k] |
| reg_wen | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 config, 1 flush, 2 hits, 3 misses |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (flush reads 0) |

## Verification
Cycle-level rules are checked by the bound assertions on every cycle. These cover the hit-to-response and miss-to-fetch timing, the one-cycle fetch pulse, `lk_ready` staying low while a fetch is outstanding, an empty valid vector after a flush-all, and counter increments and clears. Data correctness cannot be shown by a property: that means returning the right word of the right line, tag-selective flushes, eviction on tag conflict, and the absence of stale lines after a flush that races a fill. The bench shows these with a sweep over all 64 indices. It uses a memory model whose contents change between accesses, so a stale hit and a real refetch return different words.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2
  } ptc_state_e;

  // register select codes
  localparam logic [1:0] SEL_CFG    = 2'd0;
  localparam logic [1:0] SEL_FLUSH  = 2'd1;
  localparam logic [1:0] SEL_HITS   = 2'd2;
  localparam logic [1:0] SEL_MISSES = 2'd3;

  // configuration word layout
  localparam int          CFG_STATS_BIT  = 31;
  localparam int          CFG_CLEAR_BIT  = 30;
  localparam int          CFG_ENABLE_BIT = 29;
  localparam int          CFG_MAP_W      = 6;
  localparam logic [31:0] CFG_RESET      = 32'h2000_003F;

  // flush word layout
  localparam int FLUSH_TYPE_BIT = 0;

endpackage

// File: rtl/ptc_line_store.sv
module ptc_line_store #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 22,
  parameter int LINE_W = 128,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lu_idx,
  output logic              lu_valid,
  output logic [TAG_W-1:0]  lu_tag,
  output logic [LINE_W-1:0] lu_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              fl_all,
  input  logic              fl_one,
  input  logic [IDX_W-1:0]  fl_idx,
  input  logic [TAG_W-1:0]  fl_tag,
  output logic [LINES-1:0]  valid_vec
);

  logic [LINES-1:0]  valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];

  // flush is applied first, then a fill may set its line
  always_comb begin
    valid_d = valid_q;
    if (fl_all) begin
      valid_d = '0;
    end else if (fl_one && (tag_q[fl_idx] == fl_tag)) begin
      valid_d[fl_idx] = 1'b0;
    end
    if (wr_en) begin
      valid_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_line;
    end
  end

  assign lu_valid  = valid_q[lu_idx];
  assign lu_tag    = tag_q[lu_idx];
  assign lu_line   = data_q[lu_idx];
  assign valid_vec = valid_q;

endmodule

// File: rtl/ptc_stat_counters.sv
module ptc_stat_counters #(
  parameter int CNT_W = 32,
  parameter int N_CNT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [N_CNT-1:0] inc,
  output logic [CNT_W-1:0] cnt [N_CNT]
);

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    logic [CNT_W-1:0] c_q;
    always_ff @(posedge clk) begin
      if (!rst_n)             c_q <= '0;
      else if (clr)           c_q <= '0;
      else if (en && inc[g])  c_q <= c_q + CNT_W'(1);
    end
    assign cnt[g] = c_q;
  end

endmodule

// File: rtl/ptc_ctrl.sv
module ptc_ctrl
  import ptc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 6,
  parameter int OFS_W  = 4,
  parameter int LINE_W = 128,
  localparam int WB    = $clog2(WORD_W / 8),
  localparam int SEL_W = OFS_W - WB,
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              cache_en,
  output logic              lk_ready,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              fetch_valid,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_line,
  output logic [IDX_W-1:0]  lu_idx,
  input  logic              lu_valid,
  input  logic [TAG_W-1:0]  lu_tag,
  input  logic [LINE_W-1:0] lu_line,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [LINE_W-1:0] wr_line,
  input  logic              fl_all,
  input  logic              fl_one,
  input  logic [ADDR_W-1:0] fl_addr,
  output logic [IDX_W-1:0]  fl_idx,
  output logic [TAG_W-1:0]  fl_tag,
  output logic              accept_evt,
  output logic              hit_evt,
  output logic              miss_evt,
  output logic              fill_evt
);

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] ln,
                                                  input logic [ADDR_W-1:0] a);
    return ln[a[WB +: SEL_W] * WORD_W +: WORD_W];
  endfunction

  ptc_state_e        state_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              pend_cached_q;
  logic              pend_kill_q;
  logic              flush_hits_pend;
  logic              kill_now;
  logic              unused_low;

  assign unused_low = ^{lk_addr[WB-1:0], fl_addr[OFS_W-1:0], pend_addr_q[WB-1:0]};

  assign lk_ready   = (state_q == ST_IDLE);
  assign accept_evt = lk_valid && lk_ready;
  assign lu_idx     = idx_of(lk_addr);
  assign hit_evt    = accept_evt && cache_en && lu_valid && (lu_tag == tag_of(lk_addr));
  assign miss_evt   = accept_evt && cache_en && !hit_evt;

  assign fetch_valid = (state_q == ST_FETCH);
  assign fetch_addr  = {pend_addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

  assign fl_idx = idx_of(fl_addr);
  assign fl_tag = tag_of(fl_addr);

  // a flush that covers the outstanding line poisons the fill
  assign flush_hits_pend = fl_all ||
                           (fl_one && (fl_idx == idx_of(pend_addr_q)) &&
                            (fl_tag == tag_of(pend_addr_q)));
  assign kill_now = pend_kill_q || flush_hits_pend;

  assign fill_evt = (state_q == ST_WAIT) && fill_valid;
  assign wr_en    = fill_evt && pend_cached_q && !kill_now;
  assign wr_idx   = idx_of(pend_addr_q);
  assign wr_tag   = tag_of(pend_addr_q);
  assign wr_line  = fill_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      pend_addr_q   <= '0;
      pend_cached_q <= 1'b0;
      pend_kill_q   <= 1'b0;
      rd_valid      <= 1'b0;
      rd_data       <= '0;
    end else begin
      rd_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (hit_evt) begin
            rd_valid <= 1'b1;
            rd_data  <= pick_word(lu_line, lk_addr);
          end else if (accept_evt) begin
            state_q       <= ST_FETCH;
            pend_addr_q   <= lk_addr;
            pend_cached_q <= cache_en;
            pend_kill_q   <= 1'b0;
          end
        end
        ST_FETCH: begin
          state_q     <= ST_WAIT;
          pend_kill_q <= kill_now;
        end
        ST_WAIT: begin
          pend_kill_q <= kill_now;
          if (fill_valid) begin
            rd_valid <= 1'b1;
            rd_data  <= pick_word(fill_line, pend_addr_q);
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pte_word_cache.sv
module pte_word_cache
  import ptc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int IDX_W  = 6,
  parameter int CNT_W  = 32,
  localparam int LINE_W = WORDS * WORD_W,
  localparam int OFS_W  = $clog2(LINE_W / 8),
  localparam int TAG_W  = ADDR_W - IDX_W - OFS_W,
  localparam int LINES  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_ready,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              fetch_valid,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              reg_wen,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);

  logic                 cfg_stats_en, cfg_cache_en;
  logic [CFG_MAP_W-1:0] cfg_map;
  logic                 stat_clr;
  logic                 flush_wr, flush_all_evt, flush_one_evt;
  logic [ADDR_W-1:0]    flush_addr;

  logic                 accept_evt, hit_evt, miss_evt, fill_evt;
  logic [IDX_W-1:0]     lu_idx, wr_idx, fl_idx;
  logic                 lu_valid, wr_en;
  logic [TAG_W-1:0]     lu_tag, wr_tag, fl_tag;
  logic [LINE_W-1:0]    lu_line, wr_line;
  logic [LINES-1:0]     valid_vec;
  logic [CNT_W-1:0]     cnt [2];
  logic [CNT_W-1:0]     hit_cnt, miss_cnt;

  // configuration register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_stats_en <= CFG_RESET[CFG_STATS_BIT];
      cfg_cache_en <= CFG_RESET[CFG_ENABLE_BIT];
      cfg_map      <= CFG_RESET[CFG_MAP_W-1:0];
    end else if (reg_wen && reg_sel == SEL_CFG) begin
      cfg_stats_en <= reg_wdata[CFG_STATS_BIT];
      cfg_cache_en <= reg_wdata[CFG_ENABLE_BIT];
      cfg_map      <= reg_wdata[CFG_MAP_W-1:0];
    end
  end

  assign stat_clr = reg_wen && (reg_sel == SEL_CFG) && reg_wdata[CFG_CLEAR_BIT];

  // flush command decode: bit 0 = type, upper bits = line address
  assign flush_wr      = reg_wen && (reg_sel == SEL_FLUSH);
  assign flush_all_evt = flush_wr && !reg_wdata[FLUSH_TYPE_BIT];
  assign flush_one_evt = flush_wr &&  reg_wdata[FLUSH_TYPE_BIT];
  assign flush_addr    = reg_wdata[ADDR_W-1:0];

  ptc_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .IDX_W(IDX_W),
    .OFS_W(OFS_W), .LINE_W(LINE_W)
  ) u_ctrl (
    .clk, .rst_n, .lk_valid, .lk_addr,
    .cache_en(cfg_cache_en),
    .lk_ready, .rd_valid, .rd_data, .fetch_valid, .fetch_addr,
    .fill_valid, .fill_line,
    .lu_idx, .lu_valid, .lu_tag, .lu_line,
    .wr_en, .wr_idx, .wr_tag, .wr_line,
    .fl_all(flush_all_evt), .fl_one(flush_one_evt), .fl_addr(flush_addr),
    .fl_idx, .fl_tag,
    .accept_evt, .hit_evt, .miss_evt, .fill_evt
  );

  ptc_line_store #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
  ) u_store (
    .clk, .rst_n, .lu_idx, .lu_valid, .lu_tag, .lu_line,
    .wr_en, .wr_idx, .wr_tag, .wr_line,
    .fl_all(flush_all_evt), .fl_one(flush_one_evt), .fl_idx, .fl_tag,
    .valid_vec
  );

  ptc_stat_counters #(
    .CNT_W(CNT_W), .N_CNT(2)
  ) u_stats (
    .clk, .rst_n,
    .en(cfg_stats_en), .clr(stat_clr),
    .inc({miss_evt, hit_evt}),
    .cnt
  );

  assign hit_cnt  = cnt[0];
  assign miss_cnt = cnt[1];

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_CFG: begin
        reg_rdata[CFG_STATS_BIT]   = cfg_stats_en;
        reg_rdata[CFG_ENABLE_BIT]  = cfg_cache_en;
        reg_rdata[CFG_MAP_W-1:0]   = cfg_map;
      end
      SEL_HITS:   reg_rdata = 32'(hit_cnt);
      SEL_MISSES: reg_rdata = 32'(miss_cnt);
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pte_word_cache_chk.sv
module pte_word_cache_chk #(
  parameter int LINES = 64,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_ready,
  input logic             rd_valid,
  input logic             fetch_valid,
  input logic             accept_evt,
  input logic             hit_evt,
  input logic             miss_evt,
  input logic             flush_all_evt,
  input logic             stat_clr,
  input logic             cfg_stats_en,
  input logic             cfg_cache_en,
  input logic [CNT_W-1:0] hit_cnt,
  input logic [CNT_W-1:0] miss_cnt,
  input logic [LINES-1:0] valid_vec
);

  p_hit_returns_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> rd_valid);

  p_miss_fetches_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && !hit_evt) |=> fetch_valid);

  p_fetch_single_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> !fetch_valid);

  p_no_hit_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_cache_en |-> !(hit_evt || miss_evt));

  p_flush_all_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all_evt |=> (valid_vec == '0));

  p_hit_counts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stats_en && hit_evt && !stat_clr) |=> (hit_cnt == $past(hit_cnt) + CNT_W'(1)));

  p_miss_counts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stats_en && miss_evt && !stat_clr) |=> (miss_cnt == $past(miss_cnt) + CNT_W'(1)));

  p_frozen_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_stats_en && !stat_clr) |=> (hit_cnt == $past(hit_cnt) && miss_cnt == $past(miss_cnt)));

  p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> (hit_cnt == '0 && miss_cnt == '0));

  p_busy_during_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> !lk_ready);

endmodule

bind pte_word_cache pte_word_cache_chk #(.LINES(LINES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_ready(lk_ready), .rd_valid(rd_valid),
  .fetch_valid(fetch_valid), .accept_evt(accept_evt), .hit_evt(hit_evt),
  .miss_evt(miss_evt), .flush_all_evt(flush_all_evt), .stat_clr(stat_clr),
  .cfg_stats_en(cfg_stats_en), .cfg_cache_en(cfg_cache_en),
  .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .valid_vec(valid_vec)
);

// File: tb/test_pte_word_cache.sv
module test_pte_word_cache;

  localparam int MEM_LAT = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lk_valid = 1'b0;
  logic [31:0]  lk_addr = '0;
  logic         lk_ready;
  logic         rd_valid;
  logic [31:0]  rd_data;
  logic         fetch_valid;
  logic [31:0]  fetch_addr;
  logic         fill_valid = 1'b0;
  logic [127:0] fill_line = '0;
  logic         reg_wen = 1'b0;
  logic [1:0]   reg_sel = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  int fetch_cnt = 0;
  int gen = 1;
  logic [31:0] last_fetch = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pte_word_cache i_pte_word_cache (
    .clk, .rst_n, .lk_valid, .lk_addr, .lk_ready, .rd_valid, .rd_data,
    .fetch_valid, .fetch_addr, .fill_valid, .fill_line,
    .reg_wen, .reg_sel, .reg_wdata, .reg_rdata
  );

  // memory contents depend on a generation number, so a stale hit and a refetch differ
  function automatic logic [31:0] word_of(input logic [31:0] a, input int g);
    return {a[31:2], 2'b00} ^ (32'(g) * 32'h9E37_79B9);
  endfunction

  function automatic logic [31:0] mk_addr(input int idx, input int tag, input int w);
    return {tag[21:0], idx[5:0], w[1:0], 2'b00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (fetch_valid) begin
        fetch_cnt++;
        last_fetch = fetch_addr;
        chk("R11 ready low while fetching", {31'd0, lk_ready}, 32'd0);
        repeat (MEM_LAT) @(negedge clk);
        fill_valid = 1'b1;
        for (int k = 0; k < 4; k++) fill_line[k*32 +: 32] = word_of(last_fetch + 32'(4*k), gen);
        @(negedge clk);
        fill_valid = 1'b0;
      end
    end
  end

  task automatic reg_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic lookup(input logic [31:0] a, output logic [31:0] d,
                        output bit fetched, output int waits);
    int f0;
    f0 = fetch_cnt;
    @(negedge clk);
    while (!lk_ready) @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    waits = 0;
    while (!rd_valid && waits < 50) begin
      @(negedge clk);
      waits++;
    end
    d = rd_data;
    fetched = (fetch_cnt != f0);
  endtask

  // expect a miss: fetch issued, aligned address, fresh data
  task automatic expect_miss(input string req, input logic [31:0] a);
    logic [31:0] d; bit f; int w;
    lookup(a, d, f, w);
    chk({req, " fetched"}, {31'd0, f}, 32'd1);
    chk({req, " data"}, d, word_of(a, gen));
  endtask

  // expect a hit: no fetch, data of generation g, response next cycle
  task automatic expect_hit(input string req, input logic [31:0] a, input int g);
    logic [31:0] d; bit f; int w;
    lookup(a, d, f, w);
    chk({req, " no fetch"}, {31'd0, f}, 32'd0);
    chk({req, " data"}, d, word_of(a, g));
    chk({req, " latency"}, 32'(w), 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] d;
    bit f;
    int w, h0, m0, tg;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(2'd0, v); chk("R1 config reset", v, 32'h2000_003F);
    reg_read(2'd2, v); chk("R1 hits reset", v, 32'd0);
    reg_read(2'd3, v); chk("R1 misses reset", v, 32'd0);
    reg_read(2'd1, v); chk("R1 flush reads zero", v, 32'd0);

    // R12 field storage
    reg_write(2'd0, 32'hFFFF_FFFF);
    reg_read(2'd0, v); chk("R12 all ones readback", v, 32'hA000_003F);
    reg_write(2'd0, 32'h0000_0015);
    reg_read(2'd0, v); chk("R12 partial readback", v, 32'h0000_0015);
    reg_write(2'd0, 32'hA000_003F);

    // R1/R3/R4/R2 sweep over every index
    for (int idx = 0; idx < 64; idx++) begin
      tg = idx * 7 + 3;
      gen = idx + 1;
      lookup(mk_addr(idx, tg, idx % 4), d, f, w);
      chk("R1 R3 first access fetches", {31'd0, f}, 32'd1);
      chk("R3 aligned fetch address", last_fetch, mk_addr(idx, tg, 0));
      chk("R4 word select on miss", d, word_of(mk_addr(idx, tg, idx % 4), gen));
      gen = idx + 100;
      for (int k = 1; k < 4; k++)
        expect_hit("R2 R4 sweep hit", mk_addr(idx, tg, (idx + k) % 4), idx + 1);
    end
    reg_read(2'd2, v); chk("R9 hit count after sweep", v, 32'd192);
    reg_read(2'd3, v); chk("R9 miss count after sweep", v, 32'd64);

    // R4 conflict at one index
    gen = 500;
    expect_miss("R4 conflicting tag", mk_addr(5, 999, 0));
    gen = 501;
    expect_miss("R4 evicted tag refetched", mk_addr(5, 38, 0));
    gen = 502;
    expect_hit("R4 reinstalled", mk_addr(5, 38, 3), 501);

    // R7 flush by address
    reg_write(2'd1, mk_addr(5, 999, 0) | 32'd1);
    expect_hit("R7 tag mismatch keeps line", mk_addr(5, 38, 1), 501);
    reg_write(2'd1, mk_addr(5, 38, 2) | 32'd1);
    gen = 503;
    expect_miss("R7 matching flush invalidates", mk_addr(5, 38, 0));
    expect_hit("R7 neighbour untouched", mk_addr(6, 45, 0), 7);

    // R6 flush all (bit 0 clear, other bits ignored)
    reg_write(2'd1, 32'h1234_5670);
    gen = 600;
    expect_miss("R6 index 0 after flush-all", mk_addr(0, 3, 0));
    expect_miss("R6 index 17 after flush-all", mk_addr(17, 122, 1));
    expect_miss("R6 index 63 after flush-all", mk_addr(63, 444, 3));

    // R8 flush-all racing a fill
    gen = 700;
    fork
      lookup(mk_addr(20, 77, 2), d, f, w);
      begin
        wait (fetch_valid);
        reg_write(2'd1, 32'h0000_0000);
      end
    join
    chk("R8 walker still gets word", d, word_of(mk_addr(20, 77, 2), 700));
    gen = 701;
    expect_miss("R8 line not left valid after flush-all", mk_addr(20, 77, 2));

    // R8 flush-by-address racing a fill
    gen = 710;
    fork
      lookup(mk_addr(21, 88, 1), d, f, w);
      begin
        wait (fetch_valid);
        reg_write(2'd1, mk_addr(21, 88, 0) | 32'd1);
      end
    join
    chk("R8 walker word (by address)", d, word_of(mk_addr(21, 88, 1), 710));
    gen = 711;
    expect_miss("R8 line not left valid after address flush", mk_addr(21, 88, 1));

    // R5 caching disabled
    reg_write(2'd0, 32'h8000_003F);
    reg_read(2'd0, v); chk("R5 disable readback", v, 32'h8000_003F);
    reg_read(2'd2, v); h0 = int'(v);
    reg_read(2'd3, v); m0 = int'(v);
    gen = 800;
    expect_miss("R5 bypass first", mk_addr(30, 5, 0));
    gen = 801;
    expect_miss("R5 bypass second", mk_addr(30, 5, 0));
    expect_miss("R5 cached line bypassed", mk_addr(17, 122, 1));
    reg_read(2'd2, v); chk("R5 hits unchanged", v, 32'(h0));
    reg_read(2'd3, v); chk("R5 misses unchanged", v, 32'(m0));
    reg_write(2'd0, 32'hA000_003F);
    gen = 802;
    expect_miss("R5 nothing installed", mk_addr(30, 5, 0));

    // R10 clear
    reg_write(2'd0, 32'hE000_003F);
    reg_read(2'd0, v); chk("R10 clear bit reads zero", v, 32'hA000_003F);
    reg_read(2'd2, v); chk("R10 hits cleared", v, 32'd0);
    reg_read(2'd3, v); chk("R10 misses cleared", v, 32'd0);

    // R9 stats disabled
    reg_write(2'd0, 32'h2000_003F);
    expect_hit("R9 hit with stats off", mk_addr(30, 5, 1), 802);
    reg_read(2'd2, v); chk("R9 no count with stats off", v, 32'd0);

    // R10 clear in the same cycle as a hit
    reg_write(2'd0, 32'hA000_003F);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = mk_addr(30, 5, 2);
    reg_wen = 1'b1; reg_sel = 2'd0; reg_wdata = 32'hE000_003F;
    @(negedge clk);
    lk_valid = 1'b0; reg_wen = 1'b0;
    chk("R10 hit returned alongside clear", {31'd0, rd_valid}, 32'd1);
    reg_read(2'd2, v); chk("R10 clear beats increment", v, 32'd0);
    expect_hit("R9 counting resumes", mk_addr(30, 5, 3), 802);
    reg_read(2'd2, v); chk("R9 one hit counted", v, 32'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule